// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block decides on which clock cycle a pending interrupt may begin exception handling. A priority-resolving interrupt controller sits in front of it and gives a level request for maskable interrupts (already masked) and a level request for the non-maskable interrupt (NMI). A simple CPU sequencer sits behind it. The sequencer tells the gate when an instruction completes. It also marks the start of every instruction that writes the control/condition register, whether by a load, AND, OR or XOR. A block-move unit reports whether a move is running, whether it moves bytes or words, and on which cycles a transfer cycle ends.

The gate applies instruction-specific rules. An instruction that writes the control register gets a shadow: acceptance is refused at its own completion, so one more instruction always runs first. The request is not dropped. It is taken at the next boundary while the controller still holds it.

During a byte-mode block move nothing is taken, not even NMI. During a word-mode block move maskable requests wait, but NMI may break in at the end of a transfer cycle. In that case the return-address select tells the sequencer to save the address that follows the block-move instruction. The move's remaining count is left in its register, so software can test it and run the move again.

The decision is registered. The accept strobe is a one-cycle pulse that appears one clock after the boundary cycle it belongs to. No flow control is involved: the sequencer must act on the pulse, and the requests stay plain levels.

Top module: `int_accept_gate`

## Requirements
- R1: While rst_n is low, and after it rises with no stimulus, take_o is 0, take_src_o is 2'b00 (none) and ret_sel_o is 0; any control-register shadow is cleared.
- R2: When insn_done_i is high and bmove_busy_i is low on cycle t, with no shadow and no take on cycle t, and mi_req_i is high, take_o is 1 on cycle t+1 with take_src_o = 2'b01 (maskable).
- R3: If nmi_req_i and mi_req_i are both acceptable on the same cycle, the take on the next cycle reports take_src_o = 2'b10 (NMI).
- R4: take_o is never high on two consecutive cycles; a boundary that coincides with a take cycle is not evaluated.
- R5: A pulse on ctlreg_op_i arms a shadow that refuses every take until an insn_done_i with bmove_busy_i low has been seen after the pulse; that completion is refused and clears the shadow. If ctlreg_op_i and such a completion fall on the same cycle, the shadow is armed.
- R6: A request refused by the shadow and still held is taken at the following instruction completion.
- R7: While bmove_busy_i is high and bmove_word_i is 0 (byte mode), take_o stays 0 on the following cycle for any request, NMI included.
- R8: While bmove_busy_i is high and bmove_word_i is 1 (word mode), maskable requests are never taken; NMI is taken only one cycle after a cycle on which bmove_edge_i is high.
- R9: ret_sel_o is 1 (address after the block-move instruction) exactly on a take that comes from an NMI break into a word-mode move. On every other take it is 0 (next sequential instruction).
- R10: With insn_done_i low and no word-mode transfer edge, no request causes a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mi_req_i | input | 1 | Masked maskable-interrupt request level |
| nmi_req_i | input | 1 | NMI request level |
| insn_done_i | input | 1 | Instruction-complete strobe |
| ctlreg_op_i | input | 1 | Start of an instruction that writes the control register |
| bmove_busy_i | input | 1 | Block move in progress |
| bmove_word_i | input | 1 | Block move mode: 1 word, 0 byte |
| bmove_edge_i | input | 1 | Last cycle of a transfer cycle |
| take_o | output | 1 | One-cycle accept pulse |
| take_src_o | output | 2 | Accepted source: 00 none, 01 maskable, 10 NMI |
| ret_sel_o | output | 1 | Return address: 0 next instruction, 1 after block move |

## Verification
The gate holds only two pieces of state: the shadow flag and the registered take. A wrong value in either one shows at the ports within one clock. A shadow that stays stuck hides a take at the completion after next. A shadow that was lost lets a take through one cycle after the refused completion. A bad take register shows up as a doubled pulse or a missing pulse. The bench predicts take_o, take_src_o and ret_sel_o on every cycle, so a divergence is reported on the cycle it first reaches an output.

// File: rtl/iag_pkg.sv
package iag_pkg;
  localparam int SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 2'b00,
    SRC_MI   = 2'b01,
    SRC_NMI  = 2'b10
  } src_e;

  typedef enum logic {
    RET_SEQ  = 1'b0,
    RET_MOVE = 1'b1
  } ret_e;
endpackage

// File: rtl/iag_shadow.sv
module iag_shadow (
  input  logic clk,
  input  logic rst_n,
  input  logic ctlreg_op_i,
  input  logic insn_done_i,
  input  logic bmove_busy_i,
  output logic shadow_o
);
  logic boundary;
  assign boundary = insn_done_i && !bmove_busy_i;

  // arming wins over clearing: a coincident completion belongs to the older instruction
  always_ff @(posedge clk) begin
    if (!rst_n)            shadow_o <= 1'b0;
    else if (ctlreg_op_i)  shadow_o <= 1'b1;
    else if (boundary)     shadow_o <= 1'b0;
  end

  AST_SHADOW_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ctlreg_op_i |=> shadow_o); // R5
  AST_SHADOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_o && boundary && !ctlreg_op_i) |=> !shadow_o); // R5
endmodule

// File: rtl/iag_window.sv
module iag_window
  import iag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shadow_i,
  input  logic take_busy_i,
  input  logic mi_req_i,
  input  logic nmi_req_i,
  input  logic insn_done_i,
  input  logic bmove_busy_i,
  input  logic bmove_word_i,
  input  logic bmove_edge_i,
  output logic take_d_o,
  output src_e src_d_o,
  output ret_e ret_d_o
);
  logic insn_bnd, word_bnd, open_gate, nmi_ok, mi_ok;

  assign insn_bnd  = insn_done_i && !bmove_busy_i;
  assign word_bnd  = bmove_busy_i && bmove_word_i && bmove_edge_i;
  assign open_gate = !shadow_i && !take_busy_i;
  assign nmi_ok    = open_gate && nmi_req_i && (insn_bnd || word_bnd);
  assign mi_ok     = open_gate && mi_req_i && insn_bnd;

  always_comb begin
    take_d_o = nmi_ok || mi_ok;
    src_d_o  = SRC_NONE;
    ret_d_o  = RET_SEQ;
    if (nmi_ok) begin
      src_d_o = SRC_NMI;
      if (word_bnd) ret_d_o = RET_MOVE;
    end else if (mi_ok) begin
      src_d_o = SRC_MI;
    end
  end

  AST_MI_NEEDS_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    mi_ok |-> (insn_done_i && !bmove_busy_i)); // R8
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ok && mi_ok) |-> (src_d_o == SRC_NMI)); // R3
endmodule

// File: rtl/iag_issue.sv
module iag_issue
  import iag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_d_i,
  input  src_e src_d_i,
  input  ret_e ret_d_i,
  output logic take_o,
  output src_e src_o,
  output ret_e ret_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o <= 1'b0;
      src_o  <= SRC_NONE;
      ret_o  <= RET_SEQ;
    end else begin
      take_o <= take_d_i;
      src_o  <= src_d_i;
      ret_o  <= ret_d_i;
    end
  end

  AST_SRC_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (src_o != SRC_NONE)); // R2
endmodule

// File: rtl/int_accept_gate.sv
module int_accept_gate
  import iag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mi_req_i,
  input  logic             nmi_req_i,
  input  logic             insn_done_i,
  input  logic             ctlreg_op_i,
  input  logic             bmove_busy_i,
  input  logic             bmove_word_i,
  input  logic             bmove_edge_i,
  output logic             take_o,
  output logic [SRC_W-1:0] take_src_o,
  output logic             ret_sel_o
);
  logic shadow;
  logic take_d;
  src_e src_d, src_q;
  ret_e ret_d, ret_q;

  iag_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .ctlreg_op_i(ctlreg_op_i),
    .insn_done_i(insn_done_i), .bmove_busy_i(bmove_busy_i), .shadow_o(shadow)
  );

  iag_window u_window (
    .clk(clk), .rst_n(rst_n), .shadow_i(shadow), .take_busy_i(take_o),
    .mi_req_i(mi_req_i), .nmi_req_i(nmi_req_i), .insn_done_i(insn_done_i),
    .bmove_busy_i(bmove_busy_i), .bmove_word_i(bmove_word_i),
    .bmove_edge_i(bmove_edge_i), .take_d_o(take_d), .src_d_o(src_d), .ret_d_o(ret_d)
  );

  iag_issue u_issue (
    .clk(clk), .rst_n(rst_n), .take_d_i(take_d), .src_d_i(src_d), .ret_d_i(ret_d),
    .take_o(take_o), .src_o(src_q), .ret_o(ret_q)
  );

  assign take_src_o = src_q;
  assign ret_sel_o  = ret_q;

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R4
  AST_BYTE_MOVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bmove_busy_i && !bmove_word_i) |=> !take_o); // R7
  AST_WORD_MOVE_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bmove_busy_i && bmove_word_i) |=> (!take_o || take_src_o == SRC_NMI)); // R8
  AST_WORD_MOVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bmove_busy_i && !bmove_edge_i) |=> !take_o); // R8
  AST_SHADOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    shadow |=> !take_o); // R5
  AST_RET_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ret_sel_o) |-> (take_src_o == SRC_NMI)); // R9
  AST_NO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_done_i && !bmove_edge_i) |=> !take_o); // R10
endmodule

// File: tb/tb_int_accept_gate.sv
module tb_int_accept_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mi, nmi, done, ctl, busy, word, edge_s;
  logic take;
  logic [1:0] src;
  logic ret;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic m_shadow, m_take;
  logic e_take, e_ret;
  logic [1:0] e_src;

  always #2.5 clk = ~clk;

  int_accept_gate dut (
    .clk(clk), .rst_n(rst_n), .mi_req_i(mi), .nmi_req_i(nmi), .insn_done_i(done),
    .ctlreg_op_i(ctl), .bmove_busy_i(busy), .bmove_word_i(word), .bmove_edge_i(edge_s),
    .take_o(take), .take_src_o(src), .ret_sel_o(ret)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of();
    if (busy && !word) return "R7";
    if (busy) return (nmi && edge_s) ? "R9" : "R8";
    if (m_take) return "R4";
    if (m_shadow) return "R5";
    if (!done) return "R10";
    if (nmi && mi) return "R3";
    return "R2";
  endfunction

  // requirement-level prediction of the next-cycle outputs
  task automatic predict();
    logic ib, wb, open;
    ib = done && !busy;
    wb = busy && word && edge_s;
    open = !m_shadow && !m_take;
    e_take = 1'b0; e_src = 2'b00; e_ret = 1'b0;
    if (open && nmi && (ib || wb)) begin
      e_take = 1'b1; e_src = 2'b10; e_ret = wb;
    end else if (open && mi && ib) begin
      e_take = 1'b1; e_src = 2'b01;
    end
  endtask

  task automatic step(input logic i_mi, input logic i_nmi, input logic i_done,
                      input logic i_ctl, input logic i_busy, input logic i_word,
                      input logic i_edge, input string req);
    string t;
    @(negedge clk);
    mi = i_mi; nmi = i_nmi; done = i_done; ctl = i_ctl;
    busy = i_busy; word = i_word; edge_s = i_edge;
    predict();
    t = (req == "") ? tag_of() : req;
    @(posedge clk);
    #1;
    chk(t, {take, src, ret}, {e_take, e_src, e_ret});
    m_shadow = ctl ? 1'b1 : ((done && !busy) ? 1'b0 : m_shadow);
    m_take = e_take;
  endtask

  initial begin
    mi = 0; nmi = 0; done = 0; ctl = 0; busy = 0; word = 0; edge_s = 0;
    m_shadow = 0; m_take = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1", {take, src, ret}, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    step(0,0,0,0,0,0,0,"R1");
    // R2 plain maskable take
    step(1,0,1,0,0,0,0,"R2");
    // R4 held request at completion on take cycle is skipped
    step(1,0,1,0,0,0,0,"R4");
    step(0,0,0,0,0,0,0,"R10");
    // R3 both at once
    step(1,1,1,0,0,0,0,"R3");
    step(0,0,0,0,0,0,0,"R4");
    // R5/R6 shadow then retake
    step(0,0,0,1,0,0,0,"R5");
    step(1,1,1,0,0,0,0,"R5");
    step(1,0,1,0,0,0,0,"R6");
    // R5 coincident arm and completion
    step(0,0,1,1,0,0,0,"R5");
    step(1,0,1,0,0,0,0,"R5");
    step(1,0,1,0,0,0,0,"R6");
    step(0,0,0,0,0,0,0,"R10");
    // R7 byte move blocks NMI at edges
    step(1,1,0,0,1,0,1,"R7");
    step(1,1,1,0,1,0,1,"R7");
    // R8 word move: mid-cycle NMI waits, maskable never
    step(1,0,1,0,1,1,1,"R8");
    step(0,1,0,0,1,1,0,"R8");
    // R9 NMI breaks in at edge
    step(1,1,0,0,1,1,1,"R9");
    step(0,0,0,0,0,0,0,"R9");
    step(0,1,1,0,0,0,0,"R9");
    step(0,0,0,0,0,0,0,"R10");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic b, w;
      b = busy; w = word;
      if ($urandom_range(0, 9) == 0) begin
        b = $urandom_range(0, 1);
        w = $urandom_range(0, 1);
      end
      step($urandom_range(0, 1), ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 9) == 0), b, w, ($urandom_range(0, 2) == 0), "");
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B));
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule